// File: doc/BRIEF.md
# Sequential 32x32 Long Multiplier (Unsigned / Signed)

The block forms the complete double-width product of two operands, either as unsigned integers or as two's-complement integers, and leaves it in two result registers: an upper word and a lower word. A one-cycle `start_i` pulse while the unit is idle captures both operands and the signedness select. The datapath then forms one half-width partial product per cycle. There are four of them: low by low, high-a by low-b, low-a by high-b and high by high. The cycle after the last one, a fold stage combines them into the result registers and raises `done_o` for one cycle.

The fold adds the two cross products with an explicit carry, which is worth 2^16 in the upper word. It then adds the shifted cross sum into the low product, and the carry out of that sum is worth 1 in the upper word. The upper half of the cross sum and the high-by-high product also go into the upper word. Signed results reuse the same unsigned array. The upper word alone is corrected: the second operand is subtracted when the first is negative, and the first operand is subtracted when the second is negative.

Top module: `long_mul32`

## Requirements
- R1: With `sign_mode_i` = 0 at the accepted start, {`acc_hi_o`, `acc_lo_o`} equals the 64-bit unsigned product of `op_a_i` and `op_b_i`.
- R2: With `sign_mode_i` = 1 at the accepted start, {`acc_hi_o`, `acc_lo_o`} equals the 64-bit two's-complement product of the two operands read as signed values.
- R3: A start is accepted at a rising edge where `start_i` = 1 and the unit is idle. The results load and `done_o` rises at the fifth rising edge after that edge, and `done_o` stays high for exactly one cycle.
- R4: `acc_hi_o` and `acc_lo_o` change only at the edge that raises `done_o`, or under reset. Otherwise they hold their value.
- R5: `start_i` and operand changes during an operation are ignored. The result of that operation uses the operands captured at acceptance, and the unit next accepts a start at the edge after the one that raises `done_o`.
- R6: Synchronous active-high `rst` clears `done_o`, both result words and any operation in progress.
- R7: Operands 0, 0x80000000 and 0xFFFFFFFF, in every pairing and in both modes, give the exact reference product, including 0x80000000 squared when signed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a multiplication; taken only when idle |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| sign_mode_i | input | 1 | 1 = signed two's-complement, 0 = unsigned |
| done_o | output | 1 | One-cycle pulse when the result registers are loaded |
| acc_hi_o | output | 32 | Upper 32 bits of the product |
| acc_lo_o | output | 32 | Lower 32 bits of the product |

## Verification
The hardest case to reach from the ports is an operation whose inputs keep changing while it runs, with a new operation accepted on the first idle edge. The stimulus holds `start_i` high and changes the operands and the mode every cycle for long stretches. The reference model therefore decides for itself which edges accept a start, and it catches both early acceptance and wrong operand capture. The carry paths are driven by the extreme operands in both modes, and a reset is pulsed in the middle of an operation.

// File: rtl/lmul_pkg.sv
package lmul_pkg;

    localparam int OP_W_DEF = 32;
    localparam int N_PART   = 4;
    localparam int STEP_W   = $clog2(N_PART);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic              accept;
        logic              cap_en;
        logic              fin;
        logic              busy;
        logic [STEP_W-1:0] step;
    } ctrl_t;

    // Step index bit 0 selects the high half of a, bit 1 the high half of b.
    function automatic logic take_hi_a(input logic [STEP_W-1:0] s);
        return s[0];
    endfunction

    function automatic logic take_hi_b(input logic [STEP_W-1:0] s);
        return s[1];
    endfunction

endpackage

// File: rtl/lmul_pp_unit.sv
module lmul_pp_unit #(
    parameter int OP_W = lmul_pkg::OP_W_DEF
) (
    input  logic [OP_W-1:0]             op_a,
    input  logic [OP_W-1:0]             op_b,
    input  logic [lmul_pkg::STEP_W-1:0] step,
    output logic [OP_W-1:0]             part
);
    localparam int HALF_W = OP_W / 2;

    logic [HALF_W-1:0] a_half;
    logic [HALF_W-1:0] b_half;

    always_comb begin
        a_half = lmul_pkg::take_hi_a(step) ? op_a[OP_W-1:HALF_W] : op_a[HALF_W-1:0];
        b_half = lmul_pkg::take_hi_b(step) ? op_b[OP_W-1:HALF_W] : op_b[HALF_W-1:0];
        part   = {{HALF_W{1'b0}}, a_half} * {{HALF_W{1'b0}}, b_half};
    end

endmodule

// File: rtl/lmul_ctrl.sv
module lmul_ctrl
    import lmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    output ctrl_t ctrl
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_PART - 1);

    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_RUN;
                        step_q  <= '0;
                    end
                end
                PH_RUN: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) phase_q <= PH_FIN;
                end
                PH_FIN:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctrl.accept = (phase_q == PH_IDLE) && start_i;
        ctrl.cap_en = (phase_q == PH_RUN);
        ctrl.fin    = (phase_q == PH_FIN);
        ctrl.busy   = (phase_q != PH_IDLE);
        ctrl.step   = step_q;
    end

endmodule

// File: rtl/lmul_fold.sv
module lmul_fold #(
    parameter int OP_W = lmul_pkg::OP_W_DEF
) (
    input  logic [OP_W-1:0] pp_ll,
    input  logic [OP_W-1:0] pp_hl,
    input  logic [OP_W-1:0] pp_lh,
    input  logic [OP_W-1:0] pp_hh,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic            sgn,
    output logic [OP_W-1:0] hi,
    output logic [OP_W-1:0] lo
);
    localparam int HALF_W = OP_W / 2;

    logic [OP_W:0]   cross_sum;
    logic [OP_W:0]   low_sum;
    logic [OP_W-1:0] cross_carry;
    logic [OP_W-1:0] hi_raw;
    logic [OP_W-1:0] fix_a;
    logic [OP_W-1:0] fix_b;

    always_comb begin
        cross_sum   = {1'b0, pp_hl} + {1'b0, pp_lh};
        low_sum     = {1'b0, pp_ll} + {1'b0, cross_sum[HALF_W-1:0], {HALF_W{1'b0}}};
        cross_carry = cross_sum[OP_W] ? (OP_W'(1) << HALF_W) : '0;
        hi_raw      = pp_hh
                    + {{HALF_W{1'b0}}, cross_sum[OP_W-1:HALF_W]}
                    + cross_carry
                    + OP_W'(low_sum[OP_W]);
        fix_a       = (sgn && op_a[OP_W-1]) ? op_b : '0;
        fix_b       = (sgn && op_b[OP_W-1]) ? op_a : '0;
        hi          = hi_raw - fix_a - fix_b;
        lo          = low_sum[OP_W-1:0];
    end

endmodule

// File: rtl/long_mul32.sv
module long_mul32
    import lmul_pkg::*;
#(
    parameter int OP_W = OP_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [OP_W-1:0] op_a_i,
    input  logic [OP_W-1:0] op_b_i,
    input  logic            sign_mode_i,
    output logic            done_o,
    output logic [OP_W-1:0] acc_hi_o,
    output logic [OP_W-1:0] acc_lo_o
);
    ctrl_t           ctrl;
    logic            busy;
    logic [OP_W-1:0] op_a_q;
    logic [OP_W-1:0] op_b_q;
    logic            sgn_q;
    logic [OP_W-1:0] part_now;
    logic [OP_W-1:0] part_q [N_PART];
    logic [OP_W-1:0] fold_hi;
    logic [OP_W-1:0] fold_lo;

    lmul_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctrl    (ctrl)
    );

    assign busy = ctrl.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a_q <= '0;
            op_b_q <= '0;
            sgn_q  <= 1'b0;
        end else if (ctrl.accept) begin
            op_a_q <= op_a_i;
            op_b_q <= op_b_i;
            sgn_q  <= sign_mode_i;
        end
    end

    lmul_pp_unit #(.OP_W(OP_W)) u_pp (
        .op_a (op_a_q),
        .op_b (op_b_q),
        .step (ctrl.step),
        .part (part_now)
    );

    for (genvar gi = 0; gi < N_PART; gi++) begin : g_part
        always_ff @(posedge clk) begin
            if (rst)
                part_q[gi] <= '0;
            else if (ctrl.cap_en && (ctrl.step == STEP_W'(gi)))
                part_q[gi] <= part_now;
        end
    end

    lmul_fold #(.OP_W(OP_W)) u_fold (
        .pp_ll (part_q[0]),
        .pp_hl (part_q[1]),
        .pp_lh (part_q[2]),
        .pp_hh (part_q[3]),
        .op_a  (op_a_q),
        .op_b  (op_b_q),
        .sgn   (sgn_q),
        .hi    (fold_hi),
        .lo    (fold_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi_o <= '0;
            acc_lo_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= ctrl.fin;
            if (ctrl.fin) begin
                acc_hi_o <= fold_hi;
                acc_lo_o <= fold_lo;
            end
        end
    end

endmodule

// File: rtl/long_mul32_chk.sv
module long_mul32_chk #(
    parameter int OP_W = lmul_pkg::OP_W_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            done_o,
    input logic [OP_W-1:0] acc_hi_o,
    input logic [OP_W-1:0] acc_lo_o,
    input logic [OP_W-1:0] op_a_q,
    input logic            busy
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R3

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i, 6));  // R3

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(rst)) |-> ($stable(acc_hi_o) && $stable(acc_lo_o)));  // R4

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(op_a_q));  // R5

    AST_NO_DONE_IN_RESET: assert property (@(posedge clk)
        $past(rst) |-> !done_o);  // R6

endmodule

bind long_mul32 long_mul32_chk #(.OP_W(OP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .done_o   (done_o),
    .acc_hi_o (acc_hi_o),
    .acc_lo_o (acc_lo_o),
    .op_a_q   (op_a_q),
    .busy     (busy)
);

// File: tb/long_mul32_tb.sv
module long_mul32_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] op_a_i;
    logic [31:0] op_b_i;
    logic        sign_mode_i;
    logic        done_o;
    logic [31:0] acc_hi_o;
    logic [31:0] acc_lo_o;

    always #10 clk = ~clk;

    long_mul32 u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .op_a_i      (op_a_i),
        .op_b_i      (op_b_i),
        .sign_mode_i (sign_mode_i),
        .done_o      (done_o),
        .acc_hi_o    (acc_hi_o),
        .acc_lo_o    (acc_lo_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    // Behavioural reference: a countdown decides acceptance, 64-bit math gives the product.
    int          m_wait;
    logic [31:0] m_a, m_b;
    logic        m_s;
    logic [31:0] e_hi, e_lo;
    logic        e_done;
    string       e_tag = "R1";

    function automatic bit is_corner(input logic [31:0] v);
        return (v == 32'h0) || (v == 32'h8000_0000) || (v == 32'hFFFF_FFFF);
    endfunction

    always @(posedge clk) begin
        chk_on = 1'b1;
        if (rst) begin
            m_wait = 0;
            e_hi   = '0;
            e_lo   = '0;
            e_done = 1'b0;
        end else begin
            e_done = 1'b0;
            if (m_wait == 0) begin
                if (start_i) begin
                    m_a    = op_a_i;
                    m_b    = op_b_i;
                    m_s    = sign_mode_i;
                    m_wait = 5;
                end
            end else begin
                m_wait = m_wait - 1;
                if (m_wait == 0) begin
                    logic [63:0] p;
                    if (m_s)
                        p = 64'($signed({{32{m_a[31]}}, m_a}) * $signed({{32{m_b[31]}}, m_b}));
                    else
                        p = {32'h0, m_a} * {32'h0, m_b};
                    e_hi   = p[63:32];
                    e_lo   = p[31:0];
                    e_done = 1'b1;
                    e_tag  = (is_corner(m_a) && is_corner(m_b)) ? "R7" : (m_s ? "R2" : "R1");
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            string vtag;
            n_cmp++;
            if (done_o !== e_done) begin
                n_bad++;
                $display("FAIL R3 R5 done_o: actual %b expected %b at %0t", done_o, e_done, $time);
            end
            vtag = rst ? "R6" : (e_done ? e_tag : "R4");
            n_cmp++;
            if (acc_hi_o !== e_hi || acc_lo_o !== e_lo) begin
                n_bad++;
                $display("FAIL %s result: actual %h_%h expected %h_%h at %0t",
                         vtag, acc_hi_o, acc_lo_o, e_hi, e_lo, $time);
            end
        end
    end

    task automatic one_op(input logic [31:0] a, input logic [31:0] b, input logic s);
        @(negedge clk);
        start_i = 1'b1; op_a_i = a; op_b_i = b; sign_mode_i = s;
        @(negedge clk);
        start_i = 1'b0; op_a_i = $urandom; op_b_i = $urandom; sign_mode_i = ~s;
        repeat (6) @(negedge clk);
    endtask

    localparam logic [31:0] CORNER [3] = '{32'h0, 32'h8000_0000, 32'hFFFF_FFFF};

    initial begin
        rst = 1'b1; start_i = 1'b0; op_a_i = '0; op_b_i = '0; sign_mode_i = 1'b0;
        repeat (3) @(negedge clk);   // R6: outputs checked zero during reset
        rst = 1'b0;

        // R1 R2: ordinary operands in both modes
        one_op(32'd3, 32'd7, 1'b0);
        one_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
        one_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
        one_op(32'hFFFF_FFF9, 32'd5, 1'b1);
        one_op(32'h0001_FFFF, 32'h0001_FFFF, 1'b0);

        // R7: every corner pairing in both modes
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                for (int s = 0; s < 2; s++)
                    one_op(CORNER[i], CORNER[j], s[0]);

        // R1 R2: random operands
        for (int k = 0; k < 60; k++)
            one_op($urandom, $urandom, k[0]);

        // R5: start held high, inputs changing every cycle, back-to-back acceptance
        for (int k = 0; k < 240; k++) begin
            @(negedge clk);
            start_i = 1'b1; op_a_i = $urandom; op_b_i = $urandom; sign_mode_i = $urandom;
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (8) @(negedge clk);

        // R6: reset in the middle of an operation
        @(negedge clk);
        start_i = 1'b1; op_a_i = 32'hDEAD_BEEF; op_b_i = 32'h0BAD_F00D; sign_mode_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        one_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule